// File: doc/BRIEF.md
# Complex multiply-accumulate DSP unit

This arithmetic unit runs signal-processing operations on two 32-bit register operands and holds its results in two private accumulators: a 32-bit one for 16-bit real arithmetic and a 64-bit one for 32x32 products and complex arithmetic. Each 32-bit operand can also be read as a complex value, with the real part in bits 31:16 and the imaginary part in bits 15:0. The unit can do real and complex multiply, multiply-accumulate and multiply-subtract. It can also do complex addition and subtraction and count the leading zeros of a word.

A surrounding core issues one operation per cycle on the issue port, as an opcode and two sources. The work runs in a two-stage pipeline. Products are formed and registered in the first stage. The accumulator or the result word is updated in the second stage. Every accepted operation produces a one-cycle `res_valid` pulse a fixed two clock edges after issue. Both accumulators can be read at any time on their own output ports.

Top module: `cmac_unit`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `res_valid`, `res_data`, `acc32` and `acc64` are all zero.
- R2: An operation with `issue_valid` high and opcode below 12 is accepted at a rising edge. `res_valid` is high for exactly one cycle, after the second rising edge. A new operation can be accepted on every edge. For accumulator opcodes 0 to 8, `res_data` is set to zero.
- R3: The 16-bit real operations use the signed product of the low halves, `src_a[15:0]` times `src_b[15:0]`. Opcode 0 loads `acc32` with that product. Opcode 1 adds it to `acc32` and opcode 2 subtracts it, both wrapping modulo 2^32.
- R4: The 32x32 operations use the full signed 64-bit product of `src_a` and `src_b`. Opcode 3 loads `acc64` with it. Opcode 4 adds it to `acc64` and opcode 5 subtracts it, both wrapping modulo 2^64.
- R5: The complex products work on ar=`a[31:16]`, ai=`a[15:0]`, br and bi (all signed). They form re=ar*br-ai*bi and im=ar*bi+ai*br. Opcode 6 loads `acc64[63:32]` with re and `acc64[31:0]` with im. Opcode 7 adds re and im into those halves and opcode 8 subtracts them. Each half wraps modulo 2^32 on its own.
- R6: Opcode 9 sets `res_data` to {ar+br, ai+bi} and opcode 10 sets it to {ar-br, ai-bi`}`. Each 16-bit half wraps on its own.
- R7: Opcode 11 sets `res_data` to the number of leading zero bits of `src_a`. The count is 32 when `src_a` is zero.
- R8: Accumulate operations issued on consecutive cycles all take effect, and no update is lost.
- R9: Opcodes 12 to 15, and cycles with `issue_valid` low, produce no `res_valid` pulse. They leave `res_data`, `acc32` and `acc64` unchanged.
- R10: Opcodes 0 to 2 leave `acc64` unchanged. Opcodes 3 to 8 leave `acc32` unchanged. Opcodes 9 to 11 change neither accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_valid | input | 1 | An operation is offered this cycle |
| issue_op | input | 4 | Opcode of the offered operation |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand |
| res_valid | output | 1 | An accepted operation completed on the last edge |
| res_data | output | 32 | Result word of the completed operation |
| acc32 | output | 32 | 32-bit accumulator |
| acc64 | output | 64 | 64-bit accumulator |

## Verification
Every result is due two rising edges after the edge that accepts the operation. This holds for `res_valid`, `res_data` and both accumulators. The bench drives the issue port on a falling edge and removes it one falling edge later. It then samples everything on the next falling edge, which lies between the second edge and the third. For pipelined bursts, the bench counts `res_valid` pulses over a window of falling edges. It checks the accumulator only after the last pulse, so that every queued update has landed.

// File: rtl/cmac_unit.sv
module cmac_unit #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_valid,
  input  logic [3:0]      issue_op,
  input  logic [DW-1:0]   src_a,
  input  logic [DW-1:0]   src_b,
  output logic            res_valid,
  output logic [DW-1:0]   res_data,
  output logic [DW-1:0]   acc32,
  output logic [2*DW-1:0] acc64
);
  localparam int HW = DW / 2;
  localparam int CW = $clog2(DW) + 1;

  localparam logic [3:0] OP_MUL16 = 4'd0, OP_MAC16 = 4'd1, OP_MSU16 = 4'd2;
  localparam logic [3:0] OP_MULW  = 4'd3, OP_MACW  = 4'd4, OP_MSUW  = 4'd5;
  localparam logic [3:0] OP_CMUL  = 4'd6, OP_CMAC  = 4'd7, OP_CMSU  = 4'd8;
  localparam logic [3:0] OP_CADD  = 4'd9, OP_CSUB  = 4'd10, OP_CLZ  = 4'd11;
  localparam logic [3:0] OP_LAST  = OP_CLZ;

  function automatic logic [CW-1:0] lead_zeros(input logic [DW-1:0] x);
    logic [CW-1:0] n;
    n = CW'(DW);
    for (int i = 0; i < DW; i++)
      if (x[i]) n = CW'(DW - 1 - i);
    return n;
  endfunction

  wire signed [HW-1:0] ar = src_a[DW-1:HW];
  wire signed [HW-1:0] ai = src_a[HW-1:0];
  wire signed [HW-1:0] br = src_b[DW-1:HW];
  wire signed [HW-1:0] bi = src_b[HW-1:0];

  wire signed [DW-1:0]   m_rr = DW'(ar) * DW'(br);
  wire signed [DW-1:0]   m_ii = DW'(ai) * DW'(bi);
  wire signed [DW-1:0]   m_ri = DW'(ar) * DW'(bi);
  wire signed [DW-1:0]   m_ir = DW'(ai) * DW'(br);
  wire signed [DW-1:0]   sa = src_a;
  wire signed [DW-1:0]   sb = src_b;
  wire signed [2*DW-1:0] m_w  = (2*DW)'(sa) * (2*DW)'(sb);

  logic [DW-1:0] word_res;
  always_comb begin
    case (issue_op)
      OP_CADD: word_res = {ar + br, ai + bi};
      OP_CSUB: word_res = {ar - br, ai - bi};
      OP_CLZ:  word_res = {{(DW-CW){1'b0}}, lead_zeros(src_a)};
      default: word_res = '0;
    endcase
  end

  // stage 1: products and word result
  logic            v1;
  logic [3:0]      op1;
  logic [DW-1:0]   p16_q, cre_q, cim_q, word_q;
  logic [2*DW-1:0] pw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1     <= 1'b0;
      op1    <= '0;
      p16_q  <= '0;
      cre_q  <= '0;
      cim_q  <= '0;
      word_q <= '0;
      pw_q   <= '0;
    end else begin
      v1     <= issue_valid && (issue_op <= OP_LAST);
      op1    <= issue_op;
      p16_q  <= m_ii;
      cre_q  <= m_rr - m_ii;
      cim_q  <= m_ri + m_ir;
      word_q <= word_res;
      pw_q   <= m_w;
    end
  end

  // stage 2: sole writer of the accumulators
  wire [DW-1:0] acc_hi = acc64[2*DW-1:DW];
  wire [DW-1:0] acc_lo = acc64[DW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      acc32     <= '0;
      acc64     <= '0;
    end else begin
      res_valid <= v1;
      if (v1) begin
        res_data <= (op1 >= OP_CADD) ? word_q : '0;
        case (op1)
          OP_MUL16: acc32 <= p16_q;
          OP_MAC16: acc32 <= acc32 + p16_q;
          OP_MSU16: acc32 <= acc32 - p16_q;
          OP_MULW:  acc64 <= pw_q;
          OP_MACW:  acc64 <= acc64 + pw_q;
          OP_MSUW:  acc64 <= acc64 - pw_q;
          OP_CMUL:  acc64 <= {cre_q, cim_q};
          OP_CMAC:  acc64 <= {acc_hi + cre_q, acc_lo + cim_q};
          OP_CMSU:  acc64 <= {acc_hi - cre_q, acc_lo - cim_q};
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmac_unit_chk.sv
module cmac_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        issue_valid,
  input logic [3:0]  issue_op,
  input logic [31:0] src_a,
  input logic [31:0] src_b,
  input logic        res_valid,
  input logic [31:0] res_data,
  input logic [31:0] acc32,
  input logic [63:0] acc64
);
  wire logic signed [31:0] lo_prod = 32'($signed(src_a[15:0])) * 32'($signed(src_b[15:0]));
  wire logic accepted = issue_valid && (issue_op <= 4'd11);

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (!res_valid && acc32 == '0 && acc64 == '0)); // R1
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) accepted |-> ##2 res_valid); // R2
  AST_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n) !accepted |-> ##2 !res_valid); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !accepted |-> ##2 $stable(res_data)); // R9
  AST_MUL16_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (issue_valid && issue_op == 4'd0) |-> ##2 (acc32 == $past(lo_prod, 2))); // R3
  AST_ACC32_KEEP: assert property (@(posedge clk) disable iff (!rst_n) !(issue_valid && issue_op <= 4'd2) |-> ##2 $stable(acc32)); // R10
  AST_ACC64_KEEP: assert property (@(posedge clk) disable iff (!rst_n) !(issue_valid && issue_op >= 4'd3 && issue_op <= 4'd8) |-> ##2 $stable(acc64)); // R10
  AST_CLZ_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (issue_valid && issue_op == 4'd11 && src_a == '0) |-> ##2 (res_data == 32'd32)); // R7
  AST_ACC_OPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (issue_valid && issue_op <= 4'd8) |-> ##2 (res_data == '0)); // R2
endmodule

bind cmac_unit cmac_unit_chk u_chk (.*);

// File: tb/cmac_unit_bench.sv
module cmac_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic [3:0]  issue_op = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic        res_valid;
  logic [31:0] res_data, acc32;
  logic [63:0] acc64;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cmac_unit u_cmac_unit (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] p16(input logic [15:0] x, input logic [15:0] y);
    return 32'($signed(x) * $signed(y));
  endfunction

  // drive one op, then sample two edges after acceptance
  task automatic run(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    issue_valid = 1'b1; issue_op = op; src_a = a; src_b = b;
    @(negedge clk);
    issue_valid = 1'b0;
    chk("R2 no early pulse", {63'd0, res_valid}, 64'd0);
    @(negedge clk);
    chk("R2 pulse due", {63'd0, res_valid}, 64'd1);
  endtask

  task automatic t_reset();
    chk("R1 res_valid", {63'd0, res_valid}, 64'd0);
    chk("R1 res_data", {32'd0, res_data}, 64'd0);
    chk("R1 acc32", {32'd0, acc32}, 64'd0);
    chk("R1 acc64", acc64, 64'd0);
  endtask

  task automatic t_real16();
    logic [31:0] e;
    run(4'd0, 32'h1234_FFFE, 32'h7777_0003);
    e = p16(16'hFFFE, 16'h0003);
    chk("R3 mul16", {32'd0, acc32}, {32'd0, e});
    chk("R2 acc op res_data zero", {32'd0, res_data}, 64'd0);
    chk("R10 acc64 untouched", acc64, 64'd0);
    run(4'd1, 32'h0000_7FFF, 32'h0000_7FFF);
    e = e + p16(16'h7FFF, 16'h7FFF);
    chk("R3 mac16", {32'd0, acc32}, {32'd0, e});
    run(4'd2, 32'h0000_8000, 32'h0000_0100);
    e = e - p16(16'h8000, 16'h0100);
    chk("R3 msu16", {32'd0, acc32}, {32'd0, e});
  endtask

  task automatic t_wide(output logic [63:0] e);
    logic [31:0] keep32;
    keep32 = acc32;
    run(4'd3, 32'hFFFF_FFFD, 32'h4000_0001);
    e = 64'($signed(32'hFFFF_FFFD)) * 64'($signed(32'h4000_0001));
    chk("R4 mul32", acc64, e);
    run(4'd4, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    e = e + 64'($signed(32'h7FFF_FFFF)) * 64'($signed(32'h7FFF_FFFF));
    chk("R4 mac32", acc64, e);
    run(4'd5, 32'h8000_0000, 32'h0000_0002);
    e = e - 64'($signed(32'h8000_0000)) * 64'($signed(32'h0000_0002));
    chk("R4 msu32", acc64, e);
    chk("R10 acc32 untouched", {32'd0, acc32}, {32'd0, keep32});
  endtask

  task automatic t_complex();
    logic [31:0] re, im;
    logic [31:0] a, b;
    a = {16'sd3, -16'sd4}; b = {-16'sd5, 16'sd7};
    run(4'd6, a, b);
    re = p16(a[31:16], b[31:16]) - p16(a[15:0], b[15:0]);
    im = p16(a[31:16], b[15:0]) + p16(a[15:0], b[31:16]);
    chk("R5 cmul", acc64, {re, im});
    a = 32'h8000_8000; b = 32'h8000_7FFF;
    run(4'd7, a, b);
    re = re + p16(a[31:16], b[31:16]) - p16(a[15:0], b[15:0]);
    im = im + p16(a[31:16], b[15:0]) + p16(a[15:0], b[31:16]);
    chk("R5 cmac", acc64, {re, im});
    a = {16'sd100, 16'sd2}; b = {16'sd9, -16'sd11};
    run(4'd8, a, b);
    re = re - (p16(a[31:16], b[31:16]) - p16(a[15:0], b[15:0]));
    im = im - (p16(a[31:16], b[15:0]) + p16(a[15:0], b[31:16]));
    chk("R5 cmsu", acc64, {re, im});
  endtask

  task automatic t_cadd();
    logic [63:0] k64;
    k64 = acc64;
    run(4'd9, 32'h7FFF_0001, 32'h0001_FFFF);
    chk("R6 cadd wrap", {32'd0, res_data}, {32'd0, 32'h8000_0000});
    run(4'd10, 32'h0005_8000, 32'h0007_0001);
    chk("R6 csub wrap", {32'd0, res_data}, {32'd0, 32'hFFFE_7FFF});
    chk("R10 acc64 kept by cadd/csub", acc64, k64);
  endtask

  task automatic t_clz();
    run(4'd11, 32'h0000_0000, 32'hFFFF_FFFF);
    chk("R7 clz zero", {32'd0, res_data}, 64'd32);
    run(4'd11, 32'h8000_0000, 32'h0);
    chk("R7 clz top", {32'd0, res_data}, 64'd0);
    run(4'd11, 32'h0001_2345, 32'h0);
    chk("R7 clz mid", {32'd0, res_data}, 64'd15);
    run(4'd11, 32'h0000_0001, 32'h0);
    chk("R7 clz one", {32'd0, res_data}, 64'd31);
  endtask

  task automatic t_burst();
    logic [31:0] e;
    int pulses;
    pulses = 0;
    run(4'd0, 32'h0, 32'h0);
    e = 32'd0;
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      if (res_valid) pulses++;
      issue_valid = 1'b1; issue_op = (i == 3) ? 4'd2 : 4'd1;
      src_a = 32'(i * 1000); src_b = 32'(i - 7);
      if (i == 3) e = e - p16(16'(i * 1000), 16'(i - 7));
      else        e = e + p16(16'(i * 1000), 16'(i - 7));
    end
    @(negedge clk);
    issue_valid = 1'b0;
    if (res_valid) pulses++;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (res_valid) pulses++;
    end
    chk("R2 one pulse per op", 64'(pulses), 64'd5);
    chk("R8 back-to-back sum", {32'd0, acc32}, {32'd0, e});
  endtask

  task automatic t_reserved();
    logic [31:0] k32, kr;
    logic [63:0] k64;
    int pulses;
    pulses = 0;
    k32 = acc32; k64 = acc64; kr = res_data;
    for (int op = 12; op <= 15; op++) begin
      @(negedge clk);
      issue_valid = 1'b1; issue_op = 4'(op);
      src_a = 32'h1357_9BDF; src_b = 32'h2468_ACE0;
      if (res_valid) pulses++;
    end
    @(negedge clk);
    issue_valid = 1'b0; issue_op = 4'd1;
    if (res_valid) pulses++;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (res_valid) pulses++;
    end
    chk("R9 no pulse", 64'(pulses), 64'd0);
    chk("R9 acc32 kept", {32'd0, acc32}, {32'd0, k32});
    chk("R9 acc64 kept", acc64, k64);
    chk("R9 res_data kept", {32'd0, res_data}, {32'd0, kr});
  endtask

  initial begin
    logic [63:0] w;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_real16();
    t_wide(w);
    t_complex();
    t_cadd();
    t_clz();
    t_burst();
    t_clz();
    t_reserved();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule